// File: doc/BRIEF.md
# Programmable Command Setup Delay Timer

This block sets how many internal clocks pass between the start of a card access cycle and the moment its command strobe may go active. The strobe can be an output enable, a write enable, an I/O read or an I/O write. Two independent setup configurations are kept. Software programs them through a small index/data register port. The access logic picks one of the two with a select input on each cycle.

Each configuration byte holds a 2-bit prescaler code and a 6-bit multiplier. The code picks a weight of 1, 16, 256 or 8192. The setup length is S = weight × multiplier + 1 clocks. When a cycle starts, the block captures the selected configuration and computes S. It then counts down and gives a one-clock setup-done pulse that lets the command go active. A busy flag covers the whole interval.

Top module: `cmd_setup_timer`

## Requirements
- R1: After synchronous reset both configuration registers hold 8'h01 (prescaler code 0, multiplier 1), and `busy` and `setup_done` are low.
- R2: The configuration byte has the multiplier in bits 5:0 and the prescaler code in bits 7:6. Codes 0, 1, 2 and 3 select weights 1, 16, 256 and 8192. The setup length is S = weight × multiplier + 1 clocks.
- R3: `set_sel` = 0 times the cycle with the register at index 8'h3A. `set_sel` = 1 times it with the register at index 8'h3D.
- R4: Suppose `cyc_start` is sampled high in clock cycle c while the block is idle. Then `setup_done` is high for exactly one cycle, cycle c+S. With a multiplier of 0, this is cycle c+1 for every prescaler code.
- R5: `busy` is high in every cycle from c+1 through c+S inclusive, and low in the cycle after the done pulse.
- R6: A `cyc_start` sampled while `busy` is high is ignored. It neither changes the running count nor launches a second interval.
- R7: A write through the index/data port updates the addressed register at the next edge. Starts sampled at later edges use the new value. The selected configuration and S are captured at the start edge, so a write during a count does not change that count.
- R8: Writes to any index other than 8'h3A and 8'h3D leave both registers unchanged. Reads of such an index return 8'h00.
- R9: `reg_rdata` is registered. It shows the stored byte at the index presented at one edge during the following cycle.
- R10: The counter covers the full range up to S = 8192 × 63 + 1 = 516097 clocks without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the index/data port |
| reg_idx | input | 8 | Register index for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the indexed register |
| cyc_start | input | 1 | Card access cycle begins |
| set_sel | input | 1 | Selects configuration set 0 or 1 for the starting cycle |
| setup_done | output | 1 | One-clock pulse ending the setup interval |
| busy | output | 1 | High while a setup interval is in progress |

## Verification
The hardest case to reach from the ports is a count that is already running when the same configuration register is rewritten and a second start arrives. To prove that the captured length stands, the stimulus starts a long interval and rewrites the active register to a short length partway through. In the same cycle it raises `cyc_start` again. It then checks that the done pulse lands at the original length and that no second pulse follows. Very long lengths cannot be swept within the cycle budget. The top prescaler code is therefore exercised with small multipliers, which still forces carries into the upper counter bits.

// File: rtl/cmd_setup_pkg.sv
package cmd_setup_pkg;
  localparam int REG_W    = 8;
  localparam int MULT_W   = 6;
  localparam int PRESC_W  = 2;
  localparam int NUM_SETS = 2;
  localparam logic [REG_W-1:0] CFG_RST = 8'h01;

  // shift amount per prescaler code: weights 1, 16, 256, 8192
  localparam int unsigned MAX_SHIFT = 13;
  localparam int unsigned MAX_PRE   = (1 << MAX_SHIFT) * ((1 << MULT_W) - 1);
  localparam int CNT_W = $clog2(MAX_PRE + 2);

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [MULT_W-1:0]  mult;
  } setup_cfg_t;

  function automatic int unsigned presc_shift(input int unsigned code);
    case (code)
      0:       return 0;
      1:       return 4;
      2:       return 8;
      default: return MAX_SHIFT;
    endcase
  endfunction
endpackage

// File: rtl/setup_cfg_regs.sv
module setup_cfg_regs
  import cmd_setup_pkg::*;
#(
  parameter logic [7:0] IDX_SET0 = 8'h3A,
  parameter logic [7:0] IDX_SET1 = 8'h3D
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [7:0]                    idx,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_SETS-1:0][REG_W-1:0] cfg_q
);
  logic [NUM_SETS-1:0] hit;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    localparam logic [7:0] MY_IDX = (g == 0) ? IDX_SET0 : IDX_SET1;
    assign hit[g] = (idx == MY_IDX);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= CFG_RST;
      else if (wr && hit[g])
        cfg_q[g] <= wdata;
    end
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SETS; i++)
      if (hit[i]) rd_mux = cfg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/setup_len_calc.sv
module setup_len_calc
  import cmd_setup_pkg::*;
(
  input  setup_cfg_t       cfg,
  output logic [CNT_W-1:0] pre_len   // S - 1 = weight * multiplier
);
  localparam int NCODES = 1 << PRESC_W;
  logic [NCODES-1:0][CNT_W-1:0] cand;

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int unsigned SH = presc_shift(c);
    assign cand[c] = CNT_W'(cfg.mult) << SH;
  end

  assign pre_len = cand[cfg.presc];
endmodule

// File: rtl/setup_down_counter.sv
module setup_down_counter
  import cmd_setup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pre_len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= pre_len;
        done   <= (pre_len == '0);
      end
    end else if (done) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (remain == CNT_W'(1)) begin
      done   <= 1'b1;
      remain <= '0;
    end else begin
      remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmd_setup_timer.sv
module cmd_setup_timer
  import cmd_setup_pkg::*;
#(
  parameter logic [7:0] IDX_SET0 = 8'h3A,
  parameter logic [7:0] IDX_SET1 = 8'h3D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_idx,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cyc_start,
  input  logic       set_sel,
  output logic       setup_done,
  output logic       busy
);
  logic [NUM_SETS-1:0][REG_W-1:0] cfg_q;
  setup_cfg_t       active_cfg;
  logic [CNT_W-1:0] pre_len;

  setup_cfg_regs #(.IDX_SET0(IDX_SET0), .IDX_SET1(IDX_SET1)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg_q(cfg_q)
  );

  assign active_cfg = setup_cfg_t'(cfg_q[set_sel]);

  setup_len_calc u_calc (.cfg(active_cfg), .pre_len(pre_len));

  setup_down_counter u_cnt (
    .clk(clk), .rst(rst), .start(cyc_start), .pre_len(pre_len),
    .busy(busy), .done(setup_done)
  );
endmodule

// File: rtl/cmd_setup_checker.sv
module cmd_setup_checker
  import cmd_setup_pkg::*;
#(
  parameter logic [7:0] IDX_SET0 = 8'h3A,
  parameter logic [7:0] IDX_SET1 = 8'h3D
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           reg_wr,
  input logic [7:0]                     reg_idx,
  input logic [7:0]                     reg_wdata,
  input logic                           cyc_start,
  input logic                           set_sel,
  input logic                           setup_done,
  input logic                           busy,
  input logic [NUM_SETS-1:0][REG_W-1:0] cfg_q
);
  // R4: done only inside an interval, and only for one cycle
  p_done_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    setup_done |-> busy);
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> !setup_done);
  // R4: multiplier 0 gives done right after start
  p_zero_mult_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && cyc_start && cfg_q[set_sel][MULT_W-1:0] == '0) |=> setup_done);
  // R5: busy rises on an idle start and falls after done
  p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && cyc_start) |=> busy);
  p_busy_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && setup_done) |=> !busy);
  // R6: a start while counting does not end the interval early
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !setup_done && cyc_start) |=> busy);
  // R7: mapped write lands at the next edge
  p_write_set0_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_idx == IDX_SET0) |=> cfg_q[0] == $past(reg_wdata));
  p_write_set1_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_idx == IDX_SET1) |=> cfg_q[1] == $past(reg_wdata));
  // R8: unmapped write leaves both registers alone
  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_idx != IDX_SET0 && reg_idx != IDX_SET1) |=> $stable(cfg_q));
endmodule

bind cmd_setup_timer cmd_setup_checker #(.IDX_SET0(IDX_SET0), .IDX_SET1(IDX_SET1)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .cyc_start(cyc_start), .set_sel(set_sel), .setup_done(setup_done), .busy(busy),
  .cfg_q(cfg_q)
);

// File: tb/cmd_setup_timer_test.sv
module cmd_setup_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_idx = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cyc_start = 1'b0;
  logic       set_sel = 1'b0;
  logic       setup_done;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cmd_setup_timer uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_start(cyc_start),
    .set_sel(set_sel), .setup_done(setup_done), .busy(busy)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 195000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
    reg_idx = idx;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic longint exp_len(input logic [7:0] cfg);
    longint w;
    case (cfg[7:6])
      2'd0: w = 1;
      2'd1: w = 16;
      2'd2: w = 256;
      default: w = 8192;
    endcase
    return w * cfg[5:0] + 1;
  endfunction

  // start a cycle, measure the cycle index of done, check busy along the way
  task automatic run_cycle(input logic sel, input longint exp_s, input string tag);
    longint n;
    bit busy_ok;
    set_sel = sel; cyc_start = 1'b1;
    @(posedge clk); @(negedge clk);
    cyc_start = 1'b0;
    n = 1; busy_ok = 1;
    while (!setup_done && n <= exp_s + 4) begin
      if (!busy) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    check(n == exp_s, {tag, " R4 done cycle"}, n, exp_s);
    check(busy_ok && busy, {tag, " R5 busy during interval"}, busy, 1);
    @(negedge clk);
    check(!busy && !setup_done, {tag, " R5 idle after done"}, busy, 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!busy && !setup_done, "R1 outputs after reset", busy, 0);
    rd_reg(8'h3A, d); check(d == 8'h01, "R1 set0 reset value", d, 8'h01);
    rd_reg(8'h3D, d); check(d == 8'h01, "R1 set1 reset value", d, 8'h01);
    run_cycle(1'b0, 2, "R1 reset length");

    // R9 registered read, R7 write then read
    wr_reg(8'h3A, 8'h45);
    reg_idx = 8'h3A;
    @(posedge clk); #1;
    check(reg_rdata == 8'h45, "R9 read after one edge", reg_rdata, 8'h45);
    @(negedge clk);

    // R8 unmapped write and read
    wr_reg(8'h3B, 8'hFF);
    rd_reg(8'h3B, d); check(d == 8'h00, "R8 unmapped read", d, 0);
    rd_reg(8'h3A, d); check(d == 8'h45, "R8 set0 untouched", d, 8'h45);
    rd_reg(8'h3D, d); check(d == 8'h01, "R8 set1 untouched", d, 8'h01);

    // R3 selection between sets
    wr_reg(8'h3D, 8'h03);
    run_cycle(1'b0, exp_len(8'h45), "R3 set0");
    run_cycle(1'b1, 4, "R3 set1");

    // R2/R4 sweep: codes 0 and 1 all multipliers, code 2 partial, code 3 small
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 64; m++) begin
        logic [7:0] cfg;
        logic s;
        if (p == 2 && m > 15 && m != 63) continue;
        if (p == 3 && m > 2) continue;
        cfg = {p[1:0], m[5:0]};
        s = m[0];
        wr_reg(s ? 8'h3D : 8'h3A, cfg);
        run_cycle(s, exp_len(cfg), $sformatf("R2 R10 code %0d mult %0d", p, m));
      end
    end

    // R6 + R7: rewrite active register mid-count and retry start
    wr_reg(8'h3A, 8'h28); // S = 41
    begin
      longint n;
      set_sel = 1'b0; cyc_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cyc_start = 1'b0;
      n = 1;
      repeat (4) begin @(negedge clk); n++; end
      reg_wr = 1'b1; reg_idx = 8'h3A; reg_wdata = 8'h00; cyc_start = 1'b1;
      @(posedge clk); @(negedge clk); n++;
      reg_wr = 1'b0; cyc_start = 1'b0;
      while (!setup_done && n <= 50) begin @(negedge clk); n++; end
      check(n == 41, "R7 R6 captured length kept", n, 41);
      @(negedge clk);
      check(!busy, "R6 no second interval", busy, 0);
      repeat (3) begin
        @(negedge clk);
        check(!setup_done, "R6 no extra done", setup_done, 0);
      end
    end
    // R7 new value used by next start (multiplier 0 -> S = 1)
    run_cycle(1'b0, 1, "R7 new value S=1");
    // R6 start held high across done cycle: done-cycle start ignored
    wr_reg(8'h3A, 8'h02);
    set_sel = 1'b0; cyc_start = 1'b1;
    repeat (3) @(negedge clk);
    check(setup_done, "R6 done at S=3", setup_done, 1);
    @(negedge clk);
    check(!busy, "R6 start in done cycle ignored", busy, 0);
    cyc_start = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule